// File: doc/BRIEF.md
# Configuration Register with Soft Reset and Interrupt Gating

This block is the configuration and interrupt-gating part of a supply and temperature monitor. It holds an 8-bit configuration register, an interrupt-source enable register, a sticky interrupt status register, a test register and an analog-output level register. All of them are reached through a simple register bus made of an address, write data, a write strobe, a read strobe and combinational read data. The serial bus engine and the analog measurement paths are outside the block. They drive the bus, and they deliver one-cycle event pulses.

Setting bit 4 of the configuration register (address 0x40) starts a soft reset, and that bit clears itself. In the clock edge that takes the write, the configuration, source-enable and status registers go back to their power-on values. The test register and the analog-output register keep their contents. Bit 1 of the configuration register is the interrupt enable. Bit 2 is an interrupt-clear bit that holds the pin quiet while it is 1, even though the status register keeps recording events. After power-up, bit 2 is 1 and bit 1 is 0, so the pin stays quiet until software writes the register.

The active-low interrupt pin comes from a registered gating state machine. Its state reflects the enable bit, the clear bit and whether any status bit is pending, as they stood at the previous clock edge. The states are:

- OFF: the enable bit is 0.
- HOLD: the enable bit is 1 and the clear bit is 1. Events are recorded, but the pin stays quiet.
- ARMED: the pin is allowed to assert, but nothing is pending.
- FIRE: the pin is driven low.

The transitions are:

- disarm: any state to OFF when the enable bit is 0.
- suppress: any state to HOLD when the enable bit and the clear bit are both 1.
- arm: to ARMED when the pin is allowed and nothing is pending.
- fire: to FIRE when the pin is allowed and something is pending.
- drain: FIRE to ARMED once the status register is empty.

Top module: `cfg_softrst_ctrl`

## Requirements
- R1: After the hard reset, reads return the following values, and irq_n is 1:
  - configuration (0x40): 0x04
  - status (0x41): 0x00
  - source enable (0x42): 0xFF
  - test (0x50): 0x00
  - analog output (0x51): 0xFF
- R2: A write to 0x40 with wdata bit 4 equal to 0 stores the byte. The stored bit 4 always reads 0.
- R3: A write to 0x40 with wdata bit 4 equal to 1 is a soft reset. From the next cycle, configuration reads 0x04, source enable reads 0xFF and status reads 0x00, whatever the other written bits were.
- R4: A soft reset leaves the test register (0x50) and the analog-output register (0x51) unchanged.
- R5: An event pulse on evt_pulse bit i sets status bit i from the next cycle, provided source-enable bit i is 1. Status bits stay set until they are cleared. An event whose enable bit is 0 is ignored. Status records events whatever the values of configuration bits 1 and 2.
- R6: A read strobe at address 0x41 clears the status at that clock edge, but an event in the same cycle still sets its bit. A soft reset in the same cycle as an event clears that event's bit.
- R7: irq_n is 0 in the cycle after an edge at which bit 1 was 1, bit 2 was 0 and some status bit was set. Otherwise irq_n is 1.
- R8: While bit 1 and bit 2 are both 1, status records events and irq_n stays 1.
- R9: Writes to 0x41 and to unmapped addresses change nothing. Reads of unmapped addresses return 0x00.
- R10: bus_rdata shows the addressed register in the same cycle, with no read latency. The test and analog-output values are also driven on their own ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; at 0x41 it clears the status register |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| evt_pulse | input | 8 | One-cycle interrupt event pulses, one per source |
| irq_n | output | 1 | Active-low interrupt pin |
| test_reg | output | 8 | Current test register value |
| aout_reg | output | 8 | Current analog-output level value |

## Verification
The hardest situations to reach are the same-cycle collisions: an event arriving at the same edge as a status-clearing read, or at the same edge as a soft-reset write. Another is a soft reset that arrives while the gating machine sits in FIRE with the test and analog-output registers loaded. Directed sequences line each of these up cycle by cycle. A long stretch of random bus traffic and event pulses then runs against a behavioural reference model, which is compared every clock, so that the gating machine moves between HOLD, ARMED and FIRE in orders that directed tests do not cover.

// File: rtl/cfgsr_pkg.sv
package cfgsr_pkg;

    // Interrupt gating states
    typedef enum logic [1:0] {
        IG_OFF   = 2'd0,
        IG_HOLD  = 2'd1,
        IG_ARMED = 2'd2,
        IG_FIRE  = 2'd3
    } gate_state_e;

    // Configuration bit positions (behaviour depends on them)
    localparam int CFG_INTEN_BIT  = 1;
    localparam int CFG_INTCLR_BIT = 2;
    localparam int CFG_SRST_BIT   = 4;

    // Decoded bus actions
    typedef struct packed {
        logic wr_cfg;
        logic wr_src;
        logic wr_test;
        logic wr_aout;
        logic rd_stat;
    } bus_dec_t;

endpackage

// File: rtl/cfgsr_regbank.sv
module cfgsr_regbank
    import cfgsr_pkg::*;
#(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] CFG_POR   = 8'h04,
    parameter logic [DW-1:0] SRC_POR   = 8'hFF,
    parameter logic [DW-1:0] TEST_POR  = 8'h00,
    parameter logic [DW-1:0] AOUT_POR  = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_dec_t      dec_i,
    input  logic [DW-1:0] wdata_i,
    output logic          srst_o,
    output logic [DW-1:0] cfg_o,
    output logic [DW-1:0] src_o,
    output logic [DW-1:0] test_o,
    output logic [DW-1:0] aout_o
);

    localparam logic [DW-1:0] SRST_MASK = {{(DW-1){1'b0}}, 1'b1} << CFG_SRST_BIT;

    logic [DW-1:0] cfg_q, src_q, test_q, aout_q;

    // Soft reset request: a configuration write with the self-clearing bit set
    assign srst_o = dec_i.wr_cfg & wdata_i[CFG_SRST_BIT];

    // Registers reinitialised by soft reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_POR;
            src_q <= SRC_POR;
        end else if (srst_o) begin
            cfg_q <= CFG_POR;
            src_q <= SRC_POR;
        end else begin
            if (dec_i.wr_cfg) cfg_q <= wdata_i & ~SRST_MASK;
            if (dec_i.wr_src) src_q <= wdata_i;
        end
    end

    // Registers that only the power-on reset touches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            test_q <= TEST_POR;
            aout_q <= AOUT_POR;
        end else begin
            if (dec_i.wr_test) test_q <= wdata_i;
            if (dec_i.wr_aout) aout_q <= wdata_i;
        end
    end

    assign cfg_o  = cfg_q;
    assign src_o  = src_q;
    assign test_o = test_q;
    assign aout_o = aout_q;

endmodule

// File: rtl/cfgsr_status.sv
module cfgsr_status #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            rd_clr_i,
    input  logic            srst_i,
    output logic [NSRC-1:0] stat_o,
    output logic            pend_o
);

    logic [NSRC-1:0] stat_q;

    // One sticky bit per source: soft reset wins, then a new event, then read-clear
    for (genvar gi = 0; gi < NSRC; gi++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       stat_q[gi] <= 1'b0;
            else if (srst_i)                  stat_q[gi] <= 1'b0;
            else if (evt_i[gi] && en_i[gi])   stat_q[gi] <= 1'b1;
            else if (rd_clr_i)                stat_q[gi] <= 1'b0;
        end
    end

    assign stat_o = stat_q;
    assign pend_o = |stat_q;

endmodule

// File: rtl/cfgsr_gate_fsm.sv
module cfgsr_gate_fsm
    import cfgsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic int_en_i,
    input  logic int_clr_i,
    input  logic pend_i,
    output logic irq_n_o
);

    gate_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IG_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IG_OFF: begin
                if (int_en_i) begin
                    if (int_clr_i)   state_d = IG_HOLD;   // suppress
                    else if (pend_i) state_d = IG_FIRE;   // fire
                    else             state_d = IG_ARMED;  // arm
                end
            end
            IG_HOLD: begin
                if (!int_en_i)       state_d = IG_OFF;    // disarm
                else if (!int_clr_i) state_d = pend_i ? IG_FIRE : IG_ARMED;
            end
            IG_ARMED: begin
                if (!int_en_i)       state_d = IG_OFF;    // disarm
                else if (int_clr_i)  state_d = IG_HOLD;   // suppress
                else if (pend_i)     state_d = IG_FIRE;   // fire
            end
            IG_FIRE: begin
                if (!int_en_i)       state_d = IG_OFF;    // disarm
                else if (int_clr_i)  state_d = IG_HOLD;   // suppress
                else if (!pend_i)    state_d = IG_ARMED;  // drain
            end
            default:                 state_d = IG_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        irq_n_o = (state_q != IG_FIRE);
    end

endmodule

// File: rtl/cfg_softrst_ctrl.sv
module cfg_softrst_ctrl
    import cfgsr_pkg::*;
#(
    parameter int            AW         = 8,
    parameter int            DW         = 8,
    parameter int            NSRC       = 8,
    parameter logic [AW-1:0] ADDR_CFG   = 8'h40,
    parameter logic [AW-1:0] ADDR_STAT  = 8'h41,
    parameter logic [AW-1:0] ADDR_SRC   = 8'h42,
    parameter logic [AW-1:0] ADDR_TEST  = 8'h50,
    parameter logic [AW-1:0] ADDR_AOUT  = 8'h51,
    parameter logic [DW-1:0] CFG_POR    = 8'h04,
    parameter logic [DW-1:0] SRC_POR    = 8'hFF,
    parameter logic [DW-1:0] TEST_POR   = 8'h00,
    parameter logic [DW-1:0] AOUT_POR   = 8'hFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] evt_pulse,
    output logic            irq_n,
    output logic [DW-1:0]   test_reg,
    output logic [DW-1:0]   aout_reg
);

    bus_dec_t        dec;
    logic            srst;
    logic            pend;
    logic [DW-1:0]   cfg_q, src_q, test_q, aout_q;
    logic [NSRC-1:0] stat_q;
    logic [DW-1:0]   stat_rd;

    // Address decode
    assign dec.wr_cfg  = bus_wr && (bus_addr == ADDR_CFG);
    assign dec.wr_src  = bus_wr && (bus_addr == ADDR_SRC);
    assign dec.wr_test = bus_wr && (bus_addr == ADDR_TEST);
    assign dec.wr_aout = bus_wr && (bus_addr == ADDR_AOUT);
    assign dec.rd_stat = bus_rd && (bus_addr == ADDR_STAT);

    cfgsr_regbank #(
        .DW(DW), .CFG_POR(CFG_POR), .SRC_POR(SRC_POR),
        .TEST_POR(TEST_POR), .AOUT_POR(AOUT_POR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .dec_i(dec), .wdata_i(bus_wdata),
        .srst_o(srst), .cfg_o(cfg_q), .src_o(src_q),
        .test_o(test_q), .aout_o(aout_q)
    );

    cfgsr_status #(.NSRC(NSRC)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse), .en_i(src_q[NSRC-1:0]),
        .rd_clr_i(dec.rd_stat), .srst_i(srst), .stat_o(stat_q), .pend_o(pend)
    );

    cfgsr_gate_fsm u_gate (
        .clk(clk), .rst_n(rst_n),
        .int_en_i(cfg_q[CFG_INTEN_BIT]), .int_clr_i(cfg_q[CFG_INTCLR_BIT]),
        .pend_i(pend), .irq_n_o(irq_n)
    );

    // Status read value, widened to the bus
    if (NSRC < DW) begin : g_stat_pad
        assign stat_rd = {{(DW-NSRC){1'b0}}, stat_q};
    end else begin : g_stat_full
        assign stat_rd = stat_q;
    end

    // Combinational read mux
    always_comb begin
        if (bus_addr == ADDR_CFG)       bus_rdata = cfg_q;
        else if (bus_addr == ADDR_STAT) bus_rdata = stat_rd;
        else if (bus_addr == ADDR_SRC)  bus_rdata = src_q;
        else if (bus_addr == ADDR_TEST) bus_rdata = test_q;
        else if (bus_addr == ADDR_AOUT) bus_rdata = aout_q;
        else                            bus_rdata = '0;
    end

    assign test_reg = test_q;
    assign aout_reg = aout_q;

endmodule

// File: rtl/cfgsr_chk.sv
module cfgsr_chk
    import cfgsr_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter int            NSRC      = 8,
    parameter logic [AW-1:0] ADDR_CFG  = 8'h40,
    parameter logic [AW-1:0] ADDR_STAT = 8'h41,
    parameter logic [DW-1:0] CFG_POR   = 8'h04,
    parameter logic [DW-1:0] SRC_POR   = 8'hFF
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [NSRC-1:0] evt_pulse,
    input logic            irq_n,
    input logic [DW-1:0]   cfg_q,
    input logic [DW-1:0]   src_q,
    input logic [DW-1:0]   test_q,
    input logic [DW-1:0]   aout_q,
    input logic [NSRC-1:0] stat_q
);

    logic            srst_w, rdclr_w, cfgwr_w, gate_w;
    logic [NSRC-1:0] hit_w;

    assign cfgwr_w = bus_wr && (bus_addr == ADDR_CFG);
    assign srst_w  = cfgwr_w && bus_wdata[CFG_SRST_BIT];
    assign rdclr_w = bus_rd && (bus_addr == ADDR_STAT);
    assign hit_w   = evt_pulse & src_q[NSRC-1:0];
    assign gate_w  = cfg_q[CFG_INTEN_BIT] && !cfg_q[CFG_INTCLR_BIT] && (|stat_q);

    // R2
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfgwr_w && !bus_wdata[CFG_SRST_BIT]) |=>
            (cfg_q == ($past(bus_wdata) & ~(DW'(1) << CFG_SRST_BIT))));

    // R3
    srst_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_w |=> (cfg_q == CFG_POR) && (src_q == SRC_POR) && (stat_q == '0));

    // R4
    srst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_w |=> ($stable(test_q) && $stable(aout_q)));

    // R5
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hit_w) && !srst_w) |=> ((stat_q & $past(hit_w)) == $past(hit_w)));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_w && !rdclr_w) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R7
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_w |=> !irq_n);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_w |=> irq_n);

endmodule

bind cfg_softrst_ctrl cfgsr_chk #(
    .AW(AW), .DW(DW), .NSRC(NSRC), .ADDR_CFG(ADDR_CFG), .ADDR_STAT(ADDR_STAT),
    .CFG_POR(CFG_POR), .SRC_POR(SRC_POR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .evt_pulse(evt_pulse), .irq_n(irq_n),
    .cfg_q(cfg_q), .src_q(src_q), .test_q(test_q), .aout_q(aout_q), .stat_q(stat_q)
);

// File: tb/cfg_softrst_ctrl_test.sv
`timescale 1ns/1ps
module cfg_softrst_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] evt_pulse = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_n;
    logic [7:0] test_reg, aout_reg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [7:0] m_cfg = 8'h04, m_stat = 8'h00, m_src = 8'hFF, m_test = 8'h00, m_aout = 8'hFF;
    logic       m_irq_n = 1'b1;

    always #2 clk = ~clk;

    cfg_softrst_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .irq_n(irq_n), .test_reg(test_reg), .aout_reg(aout_reg)
    );

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'h40:   return m_cfg;
            8'h41:   return m_stat;
            8'h42:   return m_src;
            8'h50:   return m_test;
            8'h51:   return m_aout;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at negedge, check outputs, advance model at the edge
    task automatic step(input string tag, input logic [7:0] a, input logic [7:0] d,
                        input logic wr, input logic rd, input logic [7:0] ev);
        logic srst;
        logic [7:0] nstat;
        bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd; evt_pulse = ev;
        #1;
        check8(tag, "rdata", bus_rdata, m_read(a));
        check8(tag, "irq_n", {7'b0, irq_n}, {7'b0, m_irq_n});
        check8(tag, "test_reg", test_reg, m_test);
        check8(tag, "aout_reg", aout_reg, m_aout);
        @(posedge clk);
        srst   = wr && (a == 8'h40) && d[4];
        m_irq_n = !(m_cfg[1] && !m_cfg[2] && (m_stat != 8'h00));
        nstat  = ((rd && a == 8'h41) ? 8'h00 : m_stat) | (ev & m_src);
        if (srst) begin
            m_cfg = 8'h04; m_src = 8'hFF; m_stat = 8'h00;
        end else begin
            m_stat = nstat;
            if (wr && a == 8'h40) m_cfg = d & 8'hEF;
            if (wr && a == 8'h42) m_src = d;
        end
        if (wr && a == 8'h50) m_test = d;
        if (wr && a == 8'h51) m_aout = d;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            bus_wr = 1'b0; bus_rd = 1'b0; evt_pulse = 8'h00;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        step("R1", 8'h40, 8'h00, 0, 0, 8'h00);
        step("R1", 8'h41, 8'h00, 0, 0, 8'h00);
        step("R1", 8'h42, 8'h00, 0, 0, 8'h00);
        step("R1", 8'h50, 8'h00, 0, 0, 8'h00);
        step("R1", 8'h51, 8'h00, 0, 0, 8'h00);

        // R2 plain writes, bit 4 reads 0
        step("R2", 8'h40, 8'h2B, 1, 0, 8'h00);
        step("R2", 8'h40, 8'h00, 0, 0, 8'h00);
        step("R2", 8'h40, 8'hEF, 1, 0, 8'h00);
        step("R10", 8'h40, 8'h00, 0, 0, 8'h00);

        // R8 enable with clear still set: record, pin quiet
        step("R8", 8'h40, 8'h06, 1, 0, 8'h00);
        step("R8", 8'h41, 8'h00, 0, 0, 8'h05);
        step("R8", 8'h41, 8'h00, 0, 0, 8'h00);
        step("R8", 8'h41, 8'h00, 0, 0, 8'h00);

        // R7 release the clear bit: pin falls
        step("R7", 8'h40, 8'h02, 1, 0, 8'h00);
        step("R7", 8'h41, 8'h00, 0, 0, 8'h00);
        step("R7", 8'h41, 8'h00, 0, 0, 8'h00);

        // R6 read-clear with a simultaneous event
        step("R6", 8'h41, 8'h00, 0, 1, 8'h80);
        step("R6", 8'h41, 8'h00, 0, 0, 8'h00);
        step("R6", 8'h41, 8'h00, 0, 1, 8'h00);
        step("R7", 8'h41, 8'h00, 0, 0, 8'h00);
        step("R7", 8'h41, 8'h00, 0, 0, 8'h00);

        // R5 source masking and stickiness
        step("R5", 8'h42, 8'h0F, 1, 0, 8'h00);
        step("R5", 8'h41, 8'h00, 0, 0, 8'hF0);
        step("R5", 8'h41, 8'h00, 0, 0, 8'h00);
        step("R5", 8'h41, 8'h00, 0, 0, 8'h13);
        step("R5", 8'h41, 8'h00, 0, 0, 8'h00);
        step("R5", 8'h41, 8'h00, 0, 0, 8'h00);

        // R4 load test and analog registers, then soft reset with an event
        step("R4", 8'h50, 8'h5A, 1, 0, 8'h00);
        step("R4", 8'h51, 8'h33, 1, 0, 8'h00);
        step("R3", 8'h40, 8'h17, 1, 0, 8'h01);
        step("R3", 8'h40, 8'h00, 0, 0, 8'h00);
        step("R3", 8'h41, 8'h00, 0, 0, 8'h00);
        step("R3", 8'h42, 8'h00, 0, 0, 8'h00);
        step("R4", 8'h50, 8'h00, 0, 0, 8'h00);
        step("R4", 8'h51, 8'h00, 0, 0, 8'h00);

        // R9 writes to status and unmapped addresses
        step("R9", 8'h41, 8'h00, 0, 0, 8'h22);
        step("R9", 8'h41, 8'hFF, 1, 0, 8'h00);
        step("R9", 8'h41, 8'h00, 0, 0, 8'h00);
        step("R9", 8'h77, 8'hA5, 1, 0, 8'h00);
        step("R9", 8'h77, 8'h00, 0, 0, 8'h00);
        step("R9", 8'h40, 8'h00, 0, 0, 8'h00);
        step("R9", 8'h42, 8'h00, 0, 0, 8'h00);

        // Random traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a, d, ev;
            logic wr, rd;
            case ($urandom_range(0, 6))
                0: a = 8'h40; 1: a = 8'h41; 2: a = 8'h42;
                3: a = 8'h50; 4: a = 8'h51; 5: a = 8'h41;
                default: a = 8'h3F;
            endcase
            d  = 8'($urandom);
            if (a == 8'h40 && $urandom_range(0, 3) != 0) d[4] = 1'b0;
            wr = ($urandom_range(0, 3) == 0);
            rd = ($urandom_range(0, 2) == 0);
            ev = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
            step("RND", a, d, wr, rd, ev);
        end

        finish_run();
    end

endmodule